// File: doc/BRIEF.md
# Wide FIFO Bus Access Bridge

This block lets a 32-bit, word-addressed register bus fill and drain a set of FIFOs whose entries are wider than the bus. Each FIFO owns two banks of 48-bit entries. A FIFO may also own a third bank of 32-bit entries, chosen per FIFO by a parameter. The storage for every bank sits inside the block, written so that block RAM can be inferred.

A 48-bit entry never crosses the bus in one access. To write an entry, software loads a low staging word and a high staging word, then touches a strobe address that commits the staged 48 bits to the bank. To read an entry, software first touches the strobe address with a read, which pops the head entry into an output latch, and then reads the low and high words from that latch. The FIFO id, bank, operation and word index are all encoded in the bus address. A status word per bank reports occupancy and two sticky error flags. The full and empty state of every bank is also driven on dedicated output pins.

Top module: `wide_fifo_bridge`

## Requirements
- R1: The word address is fifo×32 + bank×2 + op×8 + word. Bank 0 is A, 1 is B and 2 is C. Op 0 selects the input staging latch, op 1 the output latch, op 2 the strobe and op 3 the status word. Word 0 is the low word: entry bits 31:0, with entry byte 0 in bits 7:0. Word 1 is the high word: entry bits 47:32 in its bits 15:0.
- R2: A bus write to op 0 loads the addressed staging word. For the high word only bus bits 15:0 are kept and bits 31:16 are ignored. Reads of op 0 return the staged contents, and high-word bits 31:16 always read as zero.
- R3: Any bus write to the strobe address pushes the staged entry into the bank, whatever the data value. The staging latches keep their contents.
- R4: A bus read of the strobe address pops the head entry into the output latch and returns zero. Later reads of op 1 return the entry's low word, and the high word zero-extended. Bus writes to op 1 are ignored.
- R5: Each bank returns entries in the order they were pushed and holds up to DEPTH entries.
- R6: A push into a full bank is dropped, leaves the stored entries intact and sets the bank's sticky overflow flag.
- R7: A pop from an empty bank leaves the output latch unchanged and sets the bank's sticky underflow flag.
- R8: The status word (op 3, word 0) reads bit 0 empty, bit 1 full, bit 2 overflow and bit 3 underflow, with all other bits zero. Writing it with bit 2 or bit 3 set clears that sticky flag. Its other bits have no effect.
- R9: bank_empty[i] and bank_full[i], with i = fifo×3 + bank, follow each bank's occupancy. A bank that is not built shows empty=1 and full=0.
- R10: Bank C holds 32-bit entries and has no high word. Every word-1 address of bank C is ignored on write and reads zero.
- R11: An access is ignored, and reads zero, when any of these holds: the bank field is 3; the bank is C on a FIFO built without one; the fifo id is not below NUM_FIFOS; or word 1 is used with op 2 or op 3.
- R12: A bus read returns its data with bus_rvalid high in the cycle after the request, and only then. After reset every bank is empty, all flags are clear, all latches read zero and bus_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bank_full | output | NUM_FIFOS×3 | Full flag per bank |
| bank_empty | output | NUM_FIFOS×3 | Empty flag per bank |

## Verification
The embedded assertions check, on every cycle, properties that hold for each bank on its own. Occupancy never passes DEPTH and a bank is never full and empty at once. A dropped push always leaves overflow set and the bank still full. A pop from an empty bank keeps the output latch stable and sets underflow. A read response always follows a read request by exactly one cycle. The bench scenarios are needed for the parts that span many accesses. These are the correct address decoding, first-in first-out order across fill and drain, byte placement within the 48-bit entry, the ignored high-word bits, the rejection of invalid selections, and the status clears that act on one flag only.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  localparam int BANKS_PER_FIFO = 3;
  localparam int BUS_W          = 32;
  localparam int WIDE_W         = 48;
  localparam int NARROW_W       = 32;

  typedef enum logic [1:0] {
    OP_STAGE_IN  = 2'd0,
    OP_STAGE_OUT = 2'd1,
    OP_STROBE    = 2'd2,
    OP_STATUS    = 2'd3
  } wfb_op_e;

  localparam logic [1:0] BANK_WIDE0  = 2'd0;
  localparam logic [1:0] BANK_WIDE1  = 2'd1;
  localparam logic [1:0] BANK_NARROW = 2'd2;

  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_UDF   = 3;
endpackage

// File: rtl/wfb_decode.sv
module wfb_decode
  import wfb_pkg::*;
#(
  parameter int                     NUM_FIFOS  = 3,
  parameter logic [NUM_FIFOS-1:0]   HAS_BANK_C = 3'b100,
  parameter int                     ADDR_W     = 7,
  parameter int                     IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ok,
  output logic [IDX_W-1:0]  idx,
  output wfb_op_e           op,
  output logic              word
);
  localparam int FIFO_FW = ADDR_W - 5;

  logic [FIFO_FW-1:0] fifo_f;
  logic [1:0]         bank_f;
  logic               has_c;
  logic               fifo_ok;
  logic               bank_ok;
  logic               word_ok;

  assign fifo_f = addr[ADDR_W-1:5];
  assign op     = wfb_op_e'(addr[4:3]);
  assign bank_f = addr[2:1];
  assign word   = addr[0];

  always_comb begin
    has_c = 1'b0;
    for (int k = 0; k < NUM_FIFOS; k++) begin
      if (fifo_f == FIFO_FW'(k)) has_c = HAS_BANK_C[k];
    end
  end

  always_comb begin
    fifo_ok = (fifo_f < FIFO_FW'(NUM_FIFOS));
    bank_ok = (bank_f == BANK_WIDE0) || (bank_f == BANK_WIDE1) ||
              ((bank_f == BANK_NARROW) && has_c);
    word_ok = !word ||
              ((bank_f != BANK_NARROW) &&
               ((op == OP_STAGE_IN) || (op == OP_STAGE_OUT)));
    ok  = fifo_ok && bank_ok && word_ok;
    idx = IDX_W'(fifo_f) * IDX_W'(BANKS_PER_FIFO) + IDX_W'(bank_f);
  end
endmodule

// File: rtl/wfb_bank.sv
module wfb_bank
  import wfb_pkg::*;
#(
  parameter int ENTRY_W = 48,
  parameter int DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BUS_W-1:0]  din,
  input  logic              push,
  input  logic              pop,
  input  logic              clr_ovf,
  input  logic              clr_udf,
  output logic [WIDE_W-1:0] stage,
  output logic [WIDE_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              ovf,
  output logic              udf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HI_W  = ENTRY_W - NARROW_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] head_q;
  logic [ENTRY_W-1:0] entry_in;
  logic [BUS_W-1:0]   lo_q;
  logic [PTR_W-1:0]   wptr;
  logic [PTR_W-1:0]   rptr;
  logic [CNT_W-1:0]   count;
  logic               push_ok;
  logic               pop_ok;

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (ld_lo) lo_q <= din;
  end

  generate
    if (HI_W > 0) begin : g_wide
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)        hi_q <= '0;
        else if (ld_hi) hi_q <= din[HI_W-1:0];
      end
      assign entry_in = {hi_q, lo_q};
      assign stage    = WIDE_W'(entry_in);
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ld_hi;
      assign entry_in  = lo_q;
      assign stage     = WIDE_W'(lo_q);
    end
  endgenerate

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= entry_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         head_q <= '0;
    else if (pop_ok) head_q <= mem[rptr];
  end
  assign head = WIDE_W'(head_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (push && full)  ovf <= 1'b1;
      else if (clr_ovf)  ovf <= 1'b0;
      if (pop && empty)  udf <= 1'b1;
      else if (clr_udf)  udf <= 1'b0;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R5
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R9
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop) |=> !empty); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf); // R6
  AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> full); // R6
  AST_UDF_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> ($stable(head_q) && udf)); // R7
endmodule

// File: rtl/wide_fifo_bridge.sv
module wide_fifo_bridge
  import wfb_pkg::*;
#(
  parameter int                   NUM_FIFOS  = 3,
  parameter logic [NUM_FIFOS-1:0] HAS_BANK_C = 3'b100,
  parameter int                   DEPTH      = 16,
  parameter int                   ADDR_W     = 7,
  localparam int                  NB         = NUM_FIFOS * BANKS_PER_FIFO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [NB-1:0]     bank_full,
  output logic [NB-1:0]     bank_empty
);
  localparam int IDX_W = $clog2(NB + 1);

  logic             dec_ok;
  logic [IDX_W-1:0] dec_idx;
  wfb_op_e          dec_op;
  logic             dec_word;

  logic [WIDE_W-1:0] stage_w [NB];
  logic [WIDE_W-1:0] head_w  [NB];
  logic [NB-1:0]     ovf_w;
  logic [NB-1:0]     udf_w;
  logic [BUS_W-1:0]  rd_mux;
  logic              rd_req;

  wfb_decode #(
    .NUM_FIFOS  (NUM_FIFOS),
    .HAS_BANK_C (HAS_BANK_C),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W)
  ) u_decode (
    .addr (bus_addr),
    .ok   (dec_ok),
    .idx  (dec_idx),
    .op   (dec_op),
    .word (dec_word)
  );

  generate
    for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_fifo
      for (genvar b = 0; b < BANKS_PER_FIFO; b++) begin : g_bank
        localparam int I = f * BANKS_PER_FIFO + b;
        if (b < 2 || HAS_BANK_C[f]) begin : g_on
          logic sel;
          assign sel = bus_req && dec_ok && (dec_idx == IDX_W'(I));
          wfb_bank #(
            .ENTRY_W ((b == 2) ? NARROW_W : WIDE_W),
            .DEPTH   (DEPTH)
          ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ld_lo   (sel && bus_we && dec_op == OP_STAGE_IN && !dec_word),
            .ld_hi   (sel && bus_we && dec_op == OP_STAGE_IN && dec_word),
            .din     (bus_wdata),
            .push    (sel && bus_we && dec_op == OP_STROBE),
            .pop     (sel && !bus_we && dec_op == OP_STROBE),
            .clr_ovf (sel && bus_we && dec_op == OP_STATUS && bus_wdata[ST_OVF]),
            .clr_udf (sel && bus_we && dec_op == OP_STATUS && bus_wdata[ST_UDF]),
            .stage   (stage_w[I]),
            .head    (head_w[I]),
            .empty   (bank_empty[I]),
            .full    (bank_full[I]),
            .ovf     (ovf_w[I]),
            .udf     (udf_w[I])
          );
        end else begin : g_off
          assign stage_w[I]    = '0;
          assign head_w[I]     = '0;
          assign bank_empty[I] = 1'b1;
          assign bank_full[I]  = 1'b0;
          assign ovf_w[I]      = 1'b0;
          assign udf_w[I]      = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (dec_ok) begin
      case (dec_op)
        OP_STAGE_IN:
          rd_mux = dec_word ? BUS_W'(stage_w[dec_idx][WIDE_W-1:BUS_W])
                            : stage_w[dec_idx][BUS_W-1:0];
        OP_STAGE_OUT:
          rd_mux = dec_word ? BUS_W'(head_w[dec_idx][WIDE_W-1:BUS_W])
                            : head_w[dec_idx][BUS_W-1:0];
        OP_STATUS: begin
          rd_mux[ST_EMPTY] = bank_empty[dec_idx];
          rd_mux[ST_FULL]  = bank_full[dec_idx];
          rd_mux[ST_OVF]   = ovf_w[dec_idx];
          rd_mux[ST_UDF]   = udf_w[dec_idx];
        end
        default: rd_mux = '0;
      endcase
    end
  end

  assign rd_req = bus_req && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid); // R12
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid); // R12
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (bank_full & bank_empty) == '0); // R9
endmodule

// File: tb/wide_fifo_bridge_bench.sv
module wide_fifo_bridge_bench;
  localparam int NF = 3;
  localparam int NB = NF * 3;
  localparam int D  = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req;
  logic        bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NB-1:0] bank_full;
  logic [NB-1:0] bank_empty;

  int compared = 0;
  int mismatched = 0;

  logic [47:0] mmem [NB][D];
  int          mwp [NB];
  int          mrp [NB];
  int          mcnt [NB];
  logic [47:0] mlatch [NB];
  logic        movf [NB];
  logic        mudf [NB];

  always #5 clk = ~clk;

  wide_fifo_bridge #(.NUM_FIFOS(NF), .HAS_BANK_C(3'b100), .DEPTH(D), .ADDR_W(7))
  u_wide_fifo_bridge (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bank_full(bank_full), .bank_empty(bank_empty)
  );

  function automatic logic [6:0] adr(int f, int b, int op, int w);
    return 7'(f * 32 + b * 2 + op * 8 + w);
  endfunction

  function automatic bit present(int i);
    return (i % 3) < 2 || (i / 3) == 2;
  endfunction

  function automatic logic [NB-1:0] exp_empty();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = !present(i) || mcnt[i] == 0;
    return v;
  endfunction

  function automatic logic [NB-1:0] exp_full();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = present(i) && mcnt[i] == D;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    check("R12 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic do_push(int f, int b, logic [31:0] lo, logic [31:0] hi);
    int i;
    i = f * 3 + b;
    bus_write(adr(f, b, 0, 0), lo);
    if (b != 2) bus_write(adr(f, b, 0, 1), hi);
    bus_write(adr(f, b, 2, 0), $urandom);
    if (mcnt[i] == D) movf[i] = 1'b1;
    else begin
      mmem[i][mwp[i]] = (b == 2) ? {16'h0, lo} : {hi[15:0], lo};
      mwp[i] = (mwp[i] + 1) % D;
      mcnt[i]++;
    end
    check("R9 empty pins after push", 32'(bank_empty), 32'(exp_empty()));
    check("R9 full pins after push", 32'(bank_full), 32'(exp_full()));
  endtask

  task automatic do_pop(int f, int b);
    int i;
    logic [31:0] d;
    i = f * 3 + b;
    bus_read(adr(f, b, 2, 0), d);
    if (mcnt[i] == 0) mudf[i] = 1'b1;
    else begin
      mlatch[i] = mmem[i][mrp[i]];
      mrp[i] = (mrp[i] + 1) % D;
      mcnt[i]--;
    end
    bus_read(adr(f, b, 1, 0), d);
    check("R4 R5 R7 head low word", d, mlatch[i][31:0]);
    if (b != 2) begin
      bus_read(adr(f, b, 1, 1), d);
      check("R4 R1 head high word", d, {16'h0, mlatch[i][47:32]});
    end else begin
      bus_read(adr(f, b, 1, 1), d);
      check("R10 bank C high word reads zero", d, 32'h0);
    end
  endtask

  task automatic check_status(int f, int b);
    int i;
    logic [31:0] d;
    i = f * 3 + b;
    bus_read(adr(f, b, 3, 0), d);
    check("R8 status word", d,
          {28'h0, mudf[i], movf[i], 1'(mcnt[i] == D), 1'(mcnt[i] == 0)});
  endtask

  task automatic clear_status(int f, int b, logic [31:0] d);
    int i;
    i = f * 3 + b;
    bus_write(adr(f, b, 3, 0), d);
    if (d[2]) movf[i] = 1'b0;
    if (d[3]) mudf[i] = 1'b0;
    check_status(f, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R12 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) begin
      mwp[i] = 0; mrp[i] = 0; mcnt[i] = 0;
      mlatch[i] = '0; movf[i] = 1'b0; mudf[i] = 1'b0;
    end
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check("R12 rvalid low after reset", 32'(bus_rvalid), 32'd0);
    check("R9 all empty after reset", 32'(bank_empty), 32'h1FF);
    check("R9 none full after reset", 32'(bank_full), 32'h0);
    for (int i = 0; i < NB; i++)
      if (present(i)) check_status(i / 3, i % 3);
    bus_read(adr(0, 0, 1, 0), d);
    check("R12 output latch zero after reset", d, 32'h0);

    // R1 R2 staging and byte placement
    bus_write(adr(1, 0, 0, 0), 32'h03020100);
    bus_write(adr(1, 0, 0, 1), 32'hABCD0504);
    bus_read(adr(1, 0, 0, 0), d);
    check("R2 staged low word", d, 32'h03020100);
    bus_read(adr(1, 0, 0, 1), d);
    check("R2 high bits 31:16 ignored", d, 32'h00000504);
    bus_write(adr(1, 0, 2, 0), 32'h0);
    mmem[3][0] = 48'h050403020100; mwp[3] = 1; mcnt[3] = 1;
    check("R3 push clears empty pin", 32'(bank_empty[3]), 32'd0);
    bus_read(adr(1, 0, 0, 1), d);
    check("R3 staging kept after push", d, 32'h00000504);
    do_pop(1, 0);
    // R4 write to output latch ignored
    bus_write(adr(1, 0, 1, 0), 32'hDEADBEEF);
    bus_read(adr(1, 0, 1, 0), d);
    check("R4 write to output latch ignored", d, 32'h03020100);
    // R7 pop on empty
    do_pop(1, 0);
    check_status(1, 0);
    // R8 clears
    clear_status(1, 0, 32'h3);
    clear_status(1, 0, 32'h8);

    // R5 R6 fill past full, then drain in order
    for (int k = 0; k < D; k++) do_push(1, 1, 32'h1000 + k, 32'h55AA0000 + k);
    check("R9 full pin at DEPTH", 32'(bank_full[4]), 32'd1);
    do_push(1, 1, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check_status(1, 1);
    clear_status(1, 1, 32'h4);
    for (int k = 0; k < D; k++) do_pop(1, 1);
    check_status(1, 1);

    // R10 narrow bank
    do_push(2, 2, 32'hCAFEF00D, 32'h0);
    bus_write(adr(2, 2, 0, 1), 32'h12345678);
    bus_read(adr(2, 2, 0, 1), d);
    check("R10 bank C staging word 1 reads zero", d, 32'h0);
    do_pop(2, 2);

    // R11 invalid selections
    bus_write(adr(0, 2, 0, 0), 32'h11111111);
    bus_write(adr(0, 2, 2, 0), 32'h0);
    bus_write(adr(0, 3, 2, 0), 32'h0);
    bus_write(adr(3, 0, 2, 0), 32'h0);
    bus_write(adr(0, 0, 2, 1), 32'h0);
    check("R11 invalid pushes change nothing", 32'(bank_empty), 32'(exp_empty()));
    bus_read(adr(0, 2, 0, 0), d);
    check("R11 absent bank reads zero", d, 32'h0);
    bus_read(adr(0, 3, 3, 0), d);
    check("R11 bank 3 status reads zero", d, 32'h0);
    bus_read(adr(3, 0, 3, 0), d);
    check("R11 fifo id out of range reads zero", d, 32'h0);

    // constrained random mix
    for (int n = 0; n < 700; n++) begin
      int f, b, r;
      f = $urandom % 3;
      b = $urandom % ((f == 2) ? 3 : 2);
      r = $urandom % 10;
      if (r < 4)      do_push(f, b, $urandom, $urandom);
      else if (r < 8) do_pop(f, b);
      else if (r < 9) clear_status(f, b, $urandom % 16);
      else            check_status(f, b);
    end
    for (int i = 0; i < NB; i++)
      if (present(i)) check_status(i / 3, i % 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule